// File: doc/BRIEF.md
# Host-to-Processor Mailbox Queue

This block is the register face of a command mailbox between a host CPU and an embedded processor. The host fills a forward queue with a descriptor pointer, a descriptor length and a sequence value. It then writes a command word that carries a function number and a request for a response. That write rings a one-cycle doorbell toward the processor. The processor side completes the command by returning the sequence tag it was given, together with a 3-bit result code. The block then raises the done flag in the command word, which the host polls.

In the other direction, the processor posts a message into a reverse command word. This sets a sticky mailbox bit in an interrupt status register and, unless a mask register blocks it, drives the host interrupt line. The host clears the sticky bit by writing one to it. It acknowledges the message by writing the reverse command word with done set and the result field cleared, which returns a one-cycle acknowledge pulse to the processor.

A host may give up on a command that never completes and post a new one. The sequence tag ensures that a late completion of the old command cannot mark the new one as finished.

Top module: `mbx_host_queue`

## Requirements
- R1: After reset every mapped register reads 0, `host_irq` is low, and `fwd_doorbell` and `rev_ack` are low.
- R2: The descriptor address (0x030), descriptor length (0x034) and sequence (0x038) words read back exactly what the host last wrote. Unmapped offsets read 0.
- R3: A host write to the forward command word (0x03C) with bit 0 (wait-for-response) set does four things. It stores function ID bits [14:11] and the static-buffer bit 5 as written. It forces done (bit 1) and the result code (bits [4:2]) to 0. It drives `fwd_doorbell` high for exactly the one cycle after the write edge. It presents the sequence word's value on `fwd_tag` and the function ID on `fwd_func`.
- R4: A forward command write with bit 0 clear raises no doorbell and leaves done and the result code unchanged. All other bits take the written value.
- R5: A processor completion (`proc_fwd_done`) whose `proc_fwd_tag` equals the posted tag while a command is outstanding sets done to 1. It copies `proc_fwd_status` verbatim into bits [4:2], where 1 means success and 0 means error.
- R6: A completion that arrives while no command is outstanding leaves the forward command word unchanged.
- R7: After a command is abandoned and a new one posted with a new sequence value, a completion carrying the old tag is ignored and one carrying the new tag is accepted.
- R8: A processor post (`proc_rev_post`) loads the reverse command word (0x0BC) with the given function in [14:11], the given result code in [4:2], done 0 and bit 0 set. It also sets bit 8 of the interrupt status word (0x000).
- R9: A host write to 0x0BC stores the written word. If bit 1 is set and a reverse message is outstanding, `rev_ack` pulses high for the one cycle after the write edge. Otherwise no pulse occurs.
- R10: Writing 1 to bit 8 of 0x000 clears the sticky mailbox bit, and writing 0 leaves it set. A processor post in the same cycle as a clearing write leaves the bit set.
- R11: The mask words (0x004, 0x008) read back as written. `host_irq` equals the sticky bit gated by the inverse of bit 8 of the mask word at 0x004. A masked source still sets the sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| host_irq | output | 1 | Host mailbox interrupt |
| fwd_doorbell | output | 1 | One-cycle pulse: new forward command |
| fwd_desc_addr | output | 32 | Descriptor address word |
| fwd_desc_size | output | 32 | Descriptor length word |
| fwd_func | output | 4 | Function ID of the forward command |
| fwd_tag | output | 32 | Sequence tag latched at posting |
| proc_fwd_done | input | 1 | Processor completes the forward command |
| proc_fwd_tag | input | 32 | Tag of the command being completed |
| proc_fwd_status | input | 3 | Result code of the completion |
| proc_rev_post | input | 1 | Processor posts a reverse message |
| proc_rev_func | input | 4 | Function ID of the reverse message |
| proc_rev_status | input | 3 | Result code of the reverse message |
| rev_ack | output | 1 | One-cycle host acknowledge pulse |

## Verification
The bench targets the abandoned-command path. A design that matched completions on the outstanding flag alone would show done set for the replacement command as soon as the stale completion arrived. It also drives a processor post in the same cycle as a host clear of the sticky bit. A design that gave the clear priority would lose that interrupt. It writes command words with and without the response request. This catches a block that rings the doorbell on every write, or one that wipes done and the result code on a plain update. Finally, it re-acknowledges an already acknowledged reverse message and checks that no second acknowledge pulse reaches the processor.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // register offsets (bytes)
   localparam int OFS_IRQ_STS   = 'h000;
   localparam int OFS_MASK_BASE = 'h004;
   localparam int OFS_FWD_ADDR  = 'h030;
   localparam int OFS_FWD_SIZE  = 'h034;
   localparam int OFS_FWD_SEQ   = 'h038;
   localparam int OFS_FWD_CMD   = 'h03C;
   localparam int OFS_REV_CMD   = 'h0BC;

   // command word fields
   localparam int CMD_WAIT    = 0;
   localparam int CMD_DONE    = 1;
   localparam int CMD_STS_LO  = 2;
   localparam int CMD_STS_W   = 3;
   localparam int CMD_STATIC  = 5;
   localparam int CMD_FUNC_LO = 11;
   localparam int CMD_FUNC_W  = 4;

   // interrupt status field
   localparam int IRQ_MBX_BIT = 8;
endpackage

// File: rtl/mbx_fwd_queue.sv
module mbx_fwd_queue
   import mbx_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_we,
   input  logic [ADDR_W-1:0]     host_addr,
   input  logic [DATA_W-1:0]     host_wdata,
   input  logic                  proc_done,
   input  logic [DATA_W-1:0]     proc_tag,
   input  logic [CMD_STS_W-1:0]  proc_status,
   output logic [DATA_W-1:0]     addr_q,
   output logic [DATA_W-1:0]     size_q,
   output logic [DATA_W-1:0]     seq_q,
   output logic [DATA_W-1:0]     cmd_q,
   output logic [DATA_W-1:0]     tag_q,
   output logic                  doorbell
);
   logic wr_addr, wr_size, wr_seq, wr_cmd, post, accept, pending_q;
   logic [DATA_W-1:0] cmd_nxt;

   assign wr_addr = host_we && (host_addr == ADDR_W'(OFS_FWD_ADDR));
   assign wr_size = host_we && (host_addr == ADDR_W'(OFS_FWD_SIZE));
   assign wr_seq  = host_we && (host_addr == ADDR_W'(OFS_FWD_SEQ));
   assign wr_cmd  = host_we && (host_addr == ADDR_W'(OFS_FWD_CMD));
   assign post    = wr_cmd && host_wdata[CMD_WAIT];
   // a host posting wins over a completion in the same cycle
   assign accept  = proc_done && pending_q && (proc_tag == tag_q) && !wr_cmd;

   always_comb begin
      cmd_nxt = cmd_q;
      if (wr_cmd) begin
         cmd_nxt = host_wdata;
         if (post) begin
            cmd_nxt[CMD_DONE] = 1'b0;
            cmd_nxt[CMD_STS_LO +: CMD_STS_W] = '0;
         end else begin
            cmd_nxt[CMD_DONE] = cmd_q[CMD_DONE];
            cmd_nxt[CMD_STS_LO +: CMD_STS_W] = cmd_q[CMD_STS_LO +: CMD_STS_W];
         end
      end else if (accept) begin
         cmd_nxt[CMD_DONE] = 1'b1;
         cmd_nxt[CMD_STS_LO +: CMD_STS_W] = proc_status;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         size_q    <= '0;
         seq_q     <= '0;
         cmd_q     <= '0;
         tag_q     <= '0;
         pending_q <= 1'b0;
         doorbell  <= 1'b0;
      end else begin
         if (wr_addr) addr_q <= host_wdata;
         if (wr_size) size_q <= host_wdata;
         if (wr_seq)  seq_q  <= host_wdata;
         cmd_q    <= cmd_nxt;
         doorbell <= post;
         if (post) begin
            tag_q     <= seq_q;
            pending_q <= 1'b1;
         end else if (accept) begin
            pending_q <= 1'b0;
         end
      end
   end

   AST_DOORBELL_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      doorbell |-> (!cmd_q[CMD_DONE] && pending_q)); // R3
   AST_DONE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_q[CMD_DONE]) |-> $past(pending_q)); // R5
   AST_STALE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_done && (proc_tag != tag_q) && !host_we) |=> $stable(cmd_q)); // R7
   AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_done && !pending_q && !host_we) |=> $stable(cmd_q)); // R6
endmodule

// File: rtl/mbx_rev_queue.sv
module mbx_rev_queue
   import mbx_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_we,
   input  logic [ADDR_W-1:0]     host_addr,
   input  logic [DATA_W-1:0]     host_wdata,
   input  logic                  proc_post,
   input  logic [CMD_FUNC_W-1:0] proc_func,
   input  logic [CMD_STS_W-1:0]  proc_status,
   output logic [DATA_W-1:0]     cmd_q,
   output logic                  ack,
   output logic                  set_evt
);
   logic wr_cmd, host_ack, pending_q;

   assign wr_cmd   = host_we && (host_addr == ADDR_W'(OFS_REV_CMD));
   // a new post takes the word; an ack in the same cycle is dropped
   assign host_ack = wr_cmd && host_wdata[CMD_DONE] && pending_q && !proc_post;
   assign set_evt  = proc_post;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         pending_q <= 1'b0;
         ack       <= 1'b0;
      end else begin
         ack <= host_ack;
         if (proc_post) begin
            cmd_q <= '0;
            cmd_q[CMD_FUNC_LO +: CMD_FUNC_W] <= proc_func;
            cmd_q[CMD_STS_LO +: CMD_STS_W]   <= proc_status;
            cmd_q[CMD_WAIT]                  <= 1'b1;
            pending_q <= 1'b1;
         end else if (wr_cmd) begin
            cmd_q <= host_wdata;
            if (host_ack) pending_q <= 1'b0;
         end
      end
   end

   AST_ACK_SEES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> cmd_q[CMD_DONE]); // R9
   AST_POST_LOADS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(proc_post) |-> (cmd_q[CMD_WAIT] && !cmd_q[CMD_DONE])); // R8
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
   import mbx_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int MASK_REGS   = 2,
   parameter bit IRQ_REG_OUT = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          host_we,
   input  logic [ADDR_W-1:0]             host_addr,
   input  logic [DATA_W-1:0]             host_wdata,
   input  logic                          set_evt,
   output logic                          sts_q,
   output logic [MASK_REGS*DATA_W-1:0]   mask_flat,
   output logic                          irq
);
   logic clr;
   logic [DATA_W-1:0] mask_q [MASK_REGS];
   logic irq_raw;

   assign clr = host_we && (host_addr == ADDR_W'(OFS_IRQ_STS)) && host_wdata[IRQ_MBX_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= 1'b0;
         for (int i = 0; i < MASK_REGS; i++) mask_q[i] <= '0;
      end else begin
         if (set_evt)  sts_q <= 1'b1;
         else if (clr) sts_q <= 1'b0;
         for (int i = 0; i < MASK_REGS; i++)
            if (host_we && (host_addr == ADDR_W'(OFS_MASK_BASE + 4 * i)))
               mask_q[i] <= host_wdata;
      end
   end

   for (genvar g = 0; g < MASK_REGS; g++) begin : g_flat
      assign mask_flat[g*DATA_W +: DATA_W] = mask_q[g];
   end

   assign irq_raw = sts_q & ~mask_q[0][IRQ_MBX_BIT];

   if (IRQ_REG_OUT) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq = irq_q;
      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         $past(mask_q[0][IRQ_MBX_BIT]) |-> !irq); // R11
   end else begin : g_irq_comb
      assign irq = irq_raw;
      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         mask_q[0][IRQ_MBX_BIT] |-> !irq); // R11
      AST_IRQ_NEEDS_STS: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> sts_q); // R11
   end

   AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_evt) |=> !sts_q); // R10
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> sts_q); // R10
endmodule

// File: rtl/mbx_host_queue.sv
module mbx_host_queue
   import mbx_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int MASK_REGS   = 2,
   parameter bit IRQ_REG_OUT = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_we,
   input  logic [ADDR_W-1:0]     host_addr,
   input  logic [DATA_W-1:0]     host_wdata,
   output logic [DATA_W-1:0]     host_rdata,
   output logic                  host_irq,
   output logic                  fwd_doorbell,
   output logic [DATA_W-1:0]     fwd_desc_addr,
   output logic [DATA_W-1:0]     fwd_desc_size,
   output logic [CMD_FUNC_W-1:0] fwd_func,
   output logic [DATA_W-1:0]     fwd_tag,
   input  logic                  proc_fwd_done,
   input  logic [DATA_W-1:0]     proc_fwd_tag,
   input  logic [CMD_STS_W-1:0]  proc_fwd_status,
   input  logic                  proc_rev_post,
   input  logic [CMD_FUNC_W-1:0] proc_rev_func,
   input  logic [CMD_STS_W-1:0]  proc_rev_status,
   output logic                  rev_ack
);
   localparam int MASK_END = OFS_MASK_BASE + 4 * MASK_REGS;

   if (DATA_W < CMD_FUNC_LO + CMD_FUNC_W) begin : g_bad_width
      $error("DATA_W too narrow for the command word");
   end
   if (MASK_REGS < 1 || MASK_END > OFS_FWD_ADDR) begin : g_bad_masks
      $error("MASK_REGS must be 1..11");
   end
   if ((1 << ADDR_W) <= OFS_REV_CMD) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [DATA_W-1:0] seq_q, fwd_cmd_q, rev_cmd_q;
   logic [MASK_REGS*DATA_W-1:0] mask_flat;
   logic sts_q, rev_set;

   mbx_fwd_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fwd (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_we     (host_we),
      .host_addr   (host_addr),
      .host_wdata  (host_wdata),
      .proc_done   (proc_fwd_done),
      .proc_tag    (proc_fwd_tag),
      .proc_status (proc_fwd_status),
      .addr_q      (fwd_desc_addr),
      .size_q      (fwd_desc_size),
      .seq_q       (seq_q),
      .cmd_q       (fwd_cmd_q),
      .tag_q       (fwd_tag),
      .doorbell    (fwd_doorbell)
   );

   mbx_rev_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rev (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_we     (host_we),
      .host_addr   (host_addr),
      .host_wdata  (host_wdata),
      .proc_post   (proc_rev_post),
      .proc_func   (proc_rev_func),
      .proc_status (proc_rev_status),
      .cmd_q       (rev_cmd_q),
      .ack         (rev_ack),
      .set_evt     (rev_set)
   );

   mbx_irq_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .MASK_REGS(MASK_REGS), .IRQ_REG_OUT(IRQ_REG_OUT)
   ) i_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .set_evt    (rev_set),
      .sts_q      (sts_q),
      .mask_flat  (mask_flat),
      .irq        (host_irq)
   );

   assign fwd_func = fwd_cmd_q[CMD_FUNC_LO +: CMD_FUNC_W];

   always_comb begin
      host_rdata = '0;
      if (host_addr == ADDR_W'(OFS_IRQ_STS)) host_rdata[IRQ_MBX_BIT] = sts_q;
      if (host_addr == ADDR_W'(OFS_FWD_ADDR)) host_rdata = fwd_desc_addr;
      if (host_addr == ADDR_W'(OFS_FWD_SIZE)) host_rdata = fwd_desc_size;
      if (host_addr == ADDR_W'(OFS_FWD_SEQ))  host_rdata = seq_q;
      if (host_addr == ADDR_W'(OFS_FWD_CMD))  host_rdata = fwd_cmd_q;
      if (host_addr == ADDR_W'(OFS_REV_CMD))  host_rdata = rev_cmd_q;
      for (int i = 0; i < MASK_REGS; i++)
         if (host_addr == ADDR_W'(OFS_MASK_BASE + 4 * i))
            host_rdata = mask_flat[i*DATA_W +: DATA_W];
   end
endmodule

// File: tb/test_mbx_host_queue.sv
module test_mbx_host_queue;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [11:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_irq, fwd_doorbell, rev_ack;
   logic [31:0] fwd_desc_addr, fwd_desc_size, fwd_tag;
   logic [3:0]  fwd_func;
   logic        proc_fwd_done = 1'b0;
   logic [31:0] proc_fwd_tag = '0;
   logic [2:0]  proc_fwd_status = '0;
   logic        proc_rev_post = 1'b0;
   logic [3:0]  proc_rev_func = '0;
   logic [2:0]  proc_rev_status = '0;

   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   mbx_host_queue i_mbx_host_queue (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_irq(host_irq),
      .fwd_doorbell(fwd_doorbell), .fwd_desc_addr(fwd_desc_addr),
      .fwd_desc_size(fwd_desc_size), .fwd_func(fwd_func), .fwd_tag(fwd_tag),
      .proc_fwd_done(proc_fwd_done), .proc_fwd_tag(proc_fwd_tag),
      .proc_fwd_status(proc_fwd_status),
      .proc_rev_post(proc_rev_post), .proc_rev_func(proc_rev_func),
      .proc_rev_status(proc_rev_status), .rev_ack(rev_ack)
   );

   // {write, offset, data}; for reads data is the expected value
   localparam int NV = 13;
   localparam logic [44:0] VEC [NV] = '{
      {1'b1, 12'h030, 32'hDEADBEEF},
      {1'b1, 12'h034, 32'h00000040},
      {1'b1, 12'h038, 32'h00000007},
      {1'b0, 12'h030, 32'hDEADBEEF},
      {1'b0, 12'h034, 32'h00000040},
      {1'b0, 12'h038, 32'h00000007},
      {1'b1, 12'h004, 32'h00000100},
      {1'b0, 12'h004, 32'h00000100},
      {1'b1, 12'h008, 32'hA5A5A5A5},
      {1'b0, 12'h008, 32'hA5A5A5A5},
      {1'b1, 12'h004, 32'h00000000},
      {1'b0, 12'h004, 32'h00000000},
      {1'b0, 12'h0C0, 32'h00000000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
      host_addr = a;
      #1;
      chk(req, host_rdata, exp);
   endtask

   task automatic fwd_complete(input logic [31:0] t, input logic [2:0] s);
      @(negedge clk);
      proc_fwd_done = 1'b1; proc_fwd_tag = t; proc_fwd_status = s;
      @(negedge clk);
      proc_fwd_done = 1'b0;
   endtask

   task automatic rev_post(input logic [3:0] f, input logic [2:0] s);
      @(negedge clk);
      proc_rev_post = 1'b1; proc_rev_func = f; proc_rev_status = s;
      @(negedge clk);
      proc_rev_post = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      rd("R1 sts", 12'h000, 32'h0);
      rd("R1 fwd cmd", 12'h03C, 32'h0);
      rd("R1 rev cmd", 12'h0BC, 32'h0);
      rd("R1 addr", 12'h030, 32'h0);
      chk("R1 irq", {31'b0, host_irq}, 32'h0);
      chk("R1 doorbell", {31'b0, fwd_doorbell}, 32'h0);
      chk("R1 ack", {31'b0, rev_ack}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      // R2 and R11: table of register accesses
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][44]) wr(VEC[i][43:32], VEC[i][31:0]);
         else rd("R2/R11 table", VEC[i][43:32], VEC[i][31:0]);
      end

      // R3: post with wait, function 5, static, junk done/status
      wr(12'h03C, 32'h0000283F);
      chk("R3 doorbell", {31'b0, fwd_doorbell}, 32'h1);
      chk("R3 func", {28'b0, fwd_func}, 32'h5);
      chk("R3 tag", fwd_tag, 32'h7);
      rd("R3 word", 12'h03C, 32'h00002821);
      @(negedge clk);
      chk("R3 doorbell one cycle", {31'b0, fwd_doorbell}, 32'h0);

      // R5: success completion
      fwd_complete(32'h7, 3'd1);
      rd("R5 success", 12'h03C, 32'h00002827);

      // R6: completion with nothing outstanding
      fwd_complete(32'h7, 3'd3);
      rd("R6 idle completion", 12'h03C, 32'h00002827);

      // R4: update without wait keeps done/status, no doorbell
      wr(12'h03C, 32'h0000301E);
      chk("R4 no doorbell", {31'b0, fwd_doorbell}, 32'h0);
      rd("R4 word", 12'h03C, 32'h00003006);

      // R7: abandoned command, then stale and fresh completions
      wr(12'h038, 32'h8);
      wr(12'h03C, 32'h00000801);
      wr(12'h038, 32'h9);
      wr(12'h03C, 32'h00001001);
      chk("R7 new tag", fwd_tag, 32'h9);
      fwd_complete(32'h8, 3'd1);
      rd("R7 stale ignored", 12'h03C, 32'h00001001);
      fwd_complete(32'h9, 3'd0);
      rd("R7/R5 error accepted", 12'h03C, 32'h00001003);

      // R8: reverse post
      rev_post(4'hA, 3'd2);
      rd("R8 word", 12'h0BC, 32'h00005009);
      rd("R8 sts", 12'h000, 32'h00000100);
      chk("R11 irq unmasked", {31'b0, host_irq}, 32'h1);

      // R9: acknowledge, then duplicate acknowledge
      wr(12'h0BC, 32'h00005003);
      chk("R9 ack pulse", {31'b0, rev_ack}, 32'h1);
      rd("R9 word", 12'h0BC, 32'h00005003);
      @(negedge clk);
      chk("R9 ack one cycle", {31'b0, rev_ack}, 32'h0);
      wr(12'h0BC, 32'h00005003);
      chk("R9 no second ack", {31'b0, rev_ack}, 32'h0);

      // R10: write-one-to-clear
      wr(12'h000, 32'h0);
      rd("R10 zero write keeps", 12'h000, 32'h00000100);
      wr(12'h000, 32'h00000100);
      rd("R10 cleared", 12'h000, 32'h0);
      chk("R10 irq low", {31'b0, host_irq}, 32'h0);

      // R10: post in same cycle as clear
      @(negedge clk);
      proc_rev_post = 1'b1; proc_rev_func = 4'h3; proc_rev_status = 3'd1;
      host_we = 1'b1; host_addr = 12'h000; host_wdata = 32'h00000100;
      @(negedge clk);
      proc_rev_post = 1'b0; host_we = 1'b0;
      rd("R10 set wins", 12'h000, 32'h00000100);
      wr(12'h000, 32'h00000100);

      // R11: masked source
      wr(12'h004, 32'h00000100);
      rev_post(4'h2, 3'd0);
      rd("R11 masked sts", 12'h000, 32'h00000100);
      chk("R11 masked irq", {31'b0, host_irq}, 32'h0);
      wr(12'h004, 32'h0);
      chk("R11 unmask irq", {31'b0, host_irq}, 32'h1);
      wr(12'h000, 32'h00000100);
      chk("R11 irq after clear", {31'b0, host_irq}, 32'h0);

      finish_run();
   end
endmodule